// File: doc/BRIEF.md
# Row/Column Selected Single-Bit RAM

This block is a small random access memory that stores sixteen one-bit values. Instead of one long column of cells behind a single 4-to-16 word decoder, the cells form a square grid of four rows and four columns. The upper half of the address picks a row through one small decoder. The lower half picks a column through a second small decoder. Only the cell where the active row meets the active column takes part in an access.

The chip select gates the column decoder. When it is low, no column is active and no cell can be written or read. A single operation line chooses between reading and writing. Writes land on the rising clock edge. Reads are combinational from the addressed cell.

The output models a three-state driver as a data bit plus a drive-enable. This lets several such blocks share one return line through an external merge. The grid geometry is set by parameters. A parameter also picks the order in which the read path narrows the grid: row first, or column first.

Top module: `grid_bit_ram`

## Requirements
- R1: The cell at address `a` is the one in row `a[3:2]` and column `a[1:0]`. While reads repeat at a steady address with no write in between, `dout` holds the value most recently written to that address.
- R2: When `cs`=1 and `rnw`=0 (0 means write, 1 means read), the value on `din` is stored at a rising `clk` edge into the addressed cell. Reads from the next cycle on return it.
- R3: A write leaves the other fifteen cells unchanged, including the cells that share its row or its column.
- R4: With `cs`=0, clock edges change no cell, whatever `rnw`, `addr` and `din` carry. In that state `dout_en`=0 and `dout`=0.
- R5: With `cs`=1 and `rnw`=1, `dout_en`=1 and `dout` equals the addressed cell in the same cycle. A change of `addr` shows on `dout` with no clock edge.
- R6: With `cs`=1 and `rnw`=0, `dout_en`=0 and `dout`=0.
- R7: Writes on consecutive clock edges to different addresses each land in their own cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Active-low reset; does not clear the storage |
| cs | input | 1 | Chip select; enables the column decoder |
| rnw | input | 1 | Operation: 1 = read, 0 = write |
| addr | input | ROW_BITS+COL_BITS | Cell address; upper bits row, lower bits column |
| din | input | 1 | Data bit to store |
| dout | output | 1 | Read data; 0 whenever not driven |
| dout_en | output | 1 | High when the block drives `dout` (models three-state enable) |

## Verification
Storing into the selected cell and holding every other cell happen in the same clock edge. The row line and the column line of a write also reach six neighbours that must not change. This is provoked with walking-one and walking-zero patterns, a diagonal pattern and back-to-back writes. After each write all sixteen cells are read back and compared with a model in the bench. A second overlap is a write-mode cycle issued while deselected, with `din` opposite to the stored data. It is judged by the silent outputs during that cycle and by a full readback afterwards.

// File: rtl/grid_ram_pkg.sv
package grid_ram_pkg;
   // Operation encoding on the single read/write line
   typedef enum logic {
      OP_WRITE = 1'b0,
      OP_READ  = 1'b1
   } ram_op_e;

   // Read path narrowing order
   localparam int unsigned NARROW_ROW_FIRST = 0;
   localparam int unsigned NARROW_COL_FIRST = 1;
endpackage

// File: rtl/grid_onehot_dec.sv
module grid_onehot_dec #(
   parameter int unsigned IN_W = 2
) (
   input  logic                    en,
   input  logic [IN_W-1:0]         code,
   output logic [(1 << IN_W)-1:0]  sel
);
   localparam int unsigned OUT_N = 1 << IN_W;

   if (IN_W < 1 || IN_W > 6) begin : g_bad_width
      $error("grid_onehot_dec: IN_W must be in 1..6");
   end

   for (genvar i = 0; i < OUT_N; i++) begin : g_line
      assign sel[i] = en && (code == IN_W'(i));
   end
endmodule

// File: rtl/grid_cell_array.sv
module grid_cell_array #(
   parameter int unsigned ROWS      = 4,
   parameter int unsigned COLS      = 4,
   parameter int unsigned READ_ORDER = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [ROWS-1:0] row_sel,
   input  logic [COLS-1:0] col_sel,
   input  logic            din,
   output logic            rd_bit
);
   import grid_ram_pkg::*;

   logic [ROWS-1:0][COLS-1:0] cells;

   if (ROWS < 2 || COLS < 2) begin : g_bad_geom
      $error("grid_cell_array: grid must be at least 2x2");
   end
   if (READ_ORDER != NARROW_ROW_FIRST && READ_ORDER != NARROW_COL_FIRST) begin : g_bad_order
      $error("grid_cell_array: unknown READ_ORDER");
   end

   // Storage: a cell loads only at the crossing of write, row and column
   always_ff @(posedge clk) begin
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < COLS; c++) begin
            if (we && row_sel[r] && col_sel[c]) begin
               cells[r][c] <= din;
            end
         end
      end
   end

   // Read path variants
   if (READ_ORDER == NARROW_ROW_FIRST) begin : g_row_first
      logic [COLS-1:0] row_vec;
      always_comb begin
         row_vec = '0;
         for (int r = 0; r < ROWS; r++) begin
            row_vec = row_vec | (cells[r] & {COLS{row_sel[r]}});
         end
      end
      assign rd_bit = |(row_vec & col_sel);
   end else begin : g_col_first
      logic [ROWS-1:0] col_vec;
      for (genvar r = 0; r < ROWS; r++) begin : g_col_pick
         assign col_vec[r] = |(cells[r] & col_sel);
      end
      assign rd_bit = |(col_vec & row_sel);
   end

   // Per-cell checks
   for (genvar r = 0; r < ROWS; r++) begin : g_chk_r
      for (genvar c = 0; c < COLS; c++) begin : g_chk_c
         // R2: a selected write lands in its cell
         a_r2_write_lands : assert property (@(posedge clk) disable iff (!rst_n)
            (we && row_sel[r] && col_sel[c]) |=> (cells[r][c] == $past(din)));
         // R3: any cell not at the write crossing keeps its value
         a_r3_others_hold : assert property (@(posedge clk) disable iff (!rst_n)
            !(we && row_sel[r] && col_sel[c]) |=> $stable(cells[r][c]));
      end
   end

   // R4: no write strobe means the whole grid is frozen
   a_r4_grid_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(cells));
endmodule

// File: rtl/grid_bit_ram.sv
module grid_bit_ram #(
   parameter int unsigned ROW_BITS   = 2,
   parameter int unsigned COL_BITS   = 2,
   parameter int unsigned READ_ORDER = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cs,
   input  logic                         rnw,
   input  logic [ROW_BITS+COL_BITS-1:0] addr,
   input  logic                         din,
   output logic                         dout,
   output logic                         dout_en
);
   import grid_ram_pkg::*;

   localparam int unsigned ADDR_W = ROW_BITS + COL_BITS;
   localparam int unsigned ROWS   = 1 << ROW_BITS;
   localparam int unsigned COLS   = 1 << COL_BITS;

   if (ADDR_W > 12) begin : g_too_big
      $error("grid_bit_ram: address too wide for this cell array");
   end

   ram_op_e         op;
   logic [ROWS-1:0] row_sel;
   logic [COLS-1:0] col_sel;
   logic            wr_strobe;
   logic            rd_bit;

   assign op        = ram_op_e'(rnw);
   assign wr_strobe = cs && (op == OP_WRITE);

   // Row decoder always active; chip select enables the column decoder
   grid_onehot_dec #(.IN_W(ROW_BITS)) u_row_dec (
      .en   (1'b1),
      .code (addr[ADDR_W-1:COL_BITS]),
      .sel  (row_sel)
   );

   grid_onehot_dec #(.IN_W(COL_BITS)) u_col_dec (
      .en   (cs),
      .code (addr[COL_BITS-1:0]),
      .sel  (col_sel)
   );

   grid_cell_array #(
      .ROWS       (ROWS),
      .COLS       (COLS),
      .READ_ORDER (READ_ORDER)
   ) u_cells (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_strobe),
      .row_sel (row_sel),
      .col_sel (col_sel),
      .din     (din),
      .rd_bit  (rd_bit)
   );

   // Output stage modelling a three-state driver
   assign dout_en = cs && (op == OP_READ);
   assign dout    = dout_en ? rd_bit : 1'b0;

   // R4: deselected block is silent
   a_r4_silent_deselected : assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> (!dout_en && !dout));
   // R6: write mode never drives the line
   a_r6_silent_on_write : assert property (@(posedge clk) disable iff (!rst_n)
      (cs && !rnw) |-> (!dout_en && !dout));
   // R5: a selected read drives the line
   a_r5_read_drives : assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rnw) |-> dout_en);
   // R1: repeated reads of a steady address return a steady value
   a_r1_read_repeatable : assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rnw && $past(cs && rnw) && $stable(addr)) |-> $stable(dout));
   // R3: column decoder selects exactly one column while selected
   a_r3_one_column : assert property (@(posedge clk) disable iff (!rst_n)
      cs |-> $onehot(col_sel));
endmodule

// File: tb/tb_grid_bit_ram.sv
module tb_grid_bit_ram;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs = 1'b0;
   logic       rnw = 1'b1;
   logic [3:0] addr = '0;
   logic       din = 1'b0;
   logic       dout;
   logic       dout_en;

   int tests = 0;
   int fails = 0;
   logic model [16];

   always #5 clk = ~clk;

   grid_bit_ram dut (
      .clk (clk), .rst_n (rst_n), .cs (cs), .rnw (rnw),
      .addr (addr), .din (din), .dout (dout), .dout_en (dout_en)
   );

   task automatic check(input string req, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b (addr %0d)", req, act, exp, addr);
      end
   endtask

   // Write one cell; R6 outputs checked during the write cycle
   task automatic wr(input logic [3:0] a, input logic d);
      @(negedge clk);
      cs = 1'b1; rnw = 1'b0; addr = a; din = d;
      #1;
      check("R6 dout_en", dout_en, 1'b0);
      check("R6 dout", dout, 1'b0);
      @(posedge clk);
      model[a] = d;
   endtask

   task automatic rd(input logic [3:0] a, input string req);
      @(negedge clk);
      cs = 1'b1; rnw = 1'b1; addr = a;
      #1;
      check({req, " dout_en"}, dout_en, 1'b1);
      check({req, " dout"}, dout, model[a]);
   endtask

   task automatic read_all(input string req);
      for (int i = 0; i < 16; i++) rd(4'(i), req);
   endtask

   task automatic t_reset;
      #1;
      check("R4 reset dout_en", dout_en, 1'b0);
      check("R4 reset dout", dout, 1'b0);
   endtask

   task automatic t_init;
      for (int i = 0; i < 16; i++) wr(4'(i), 1'b0);
      read_all("R2 init");
   endtask

   task automatic t_walk(input logic bg);
      for (int k = 0; k < 16; k++) begin
         wr(4'(k), ~bg);
         read_all("R3 walk");
         wr(4'(k), bg);
      end
   endtask

   // Diagonal: R1 mapping of row addr[3:2] and column addr[1:0]
   task automatic t_diag;
      for (int i = 0; i < 16; i++) wr(4'(i), (i[3:2] == i[1:0]));
      for (int i = 0; i < 16; i++) begin
         rd(4'(i), "R1 diag");
         check("R1 diag map", dout, (i[3:2] == i[1:0]));
      end
   endtask

   // R7: back-to-back writes on consecutive edges
   task automatic t_burst;
      for (int i = 0; i < 16; i++) wr(4'(i), i[0] ^ i[2]);
      read_all("R7 burst");
   endtask

   // R4: deselected write-mode cycles with opposite data
   task automatic t_deselect;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         cs = 1'b0; rnw = 1'(i & 1); addr = 4'(i); din = ~model[i];
         #1;
         check("R4 dout_en", dout_en, 1'b0);
         check("R4 dout", dout, 1'b0);
      end
      read_all("R4 after deselect");
   endtask

   // R5: address changes show without a clock edge
   task automatic t_comb_read;
      wr(4'd5, 1'b1);
      wr(4'd6, 1'b0);
      @(negedge clk);
      cs = 1'b1; rnw = 1'b1; addr = 4'd5;
      #1; check("R5 comb a5", dout, 1'b1);
      addr = 4'd6;
      #1; check("R5 comb a6", dout, 1'b0);
      addr = 4'd5;
      #1; check("R5 comb back", dout, 1'b1);
   endtask

   initial begin
      #(200000 * 10);
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) model[i] = 1'b0;
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk) rst_n = 1'b1;
      t_init();
      t_walk(1'b0);
      t_walk(1'b1);
      t_diag();
      t_burst();
      t_deselect();
      t_comb_read();
      @(negedge clk) cs = 1'b0;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule